// File: doc/BRIEF.md
# DMA Line-Splitting Request Sequencer

This block takes one DMA transfer at a time (start byte address, byte count, direction) and cuts it into memory transactions that never cross a cache-line boundary. Only the first piece can start partway into a line, and it is shortened so that it ends at that line's boundary. Every later piece is line-aligned and as long as a full line, or as long as what is left. The pieces go out one at a time on a valid/ready request port. The sequencer then waits for the memory side to answer: with line data for a read, or with a plain acknowledgement for a write. Only after that answer does it present the next piece.

Store data comes in whole with the request and is held in a local byte store. Each piece is cut from that store and placed at its proper byte lanes in the outgoing line. For a load, the same store gathers the bytes taken from each returned line. The gathered bytes are visible upstream once completion is signalled. While a transfer is in progress the block refuses new requests outright and keeps no record of them. Malformed requests are refused with an error indication.

Top module: `dma_chunker`

## Requirements
- R1: When idle, a request with operation code 2'b00 (load) or 2'b01 (store) and a length from 1 to MAX_LEN raises `req_ok` combinationally in the same cycle. `busy` is high from the next cycle on.
- R2: A request presented while `busy` is high raises `req_full` with `req_ok` low. It is not stored, and it produces no memory transaction at any later time.
- R3: When idle, a request with operation code 2'b10 or 2'b11, a length of 0, or a length above MAX_LEN raises `req_err`. No transfer starts: `busy` and `mreq_valid` stay low.
- R4: The first piece has address equal to the start address. Its length is the full length if (address mod LINE_BYTES) + length ≤ LINE_BYTES, and LINE_BYTES − (address mod LINE_BYTES) otherwise.
- R5: Each later piece has address equal to start + bytes already answered, with the low log2(LINE_BYTES) bits zero. Its length is min(bytes remaining, LINE_BYTES). The pieces together cover exactly the requested length.
- R6: At most one piece is outstanding. After a piece is taken (valid and ready both high), `mreq_valid` stays low until the response arrives. While `mreq_valid` is high and `mreq_ready` is low, the address and length hold steady.
- R7: `mreq_line_addr` equals `mreq_addr` with its low log2(LINE_BYTES) bits cleared. `mreq_write` is 1 for a store and 0 for a load.
- R8: For a store piece at line offset o and length n, byte lane o+k of `mreq_data` (bits 8(o+k)+7 .. 8(o+k)) carries request byte (bytes already sent + k) of `req_wdata`, where byte i sits at bits 8i+7 .. 8i. All other lanes are zero.
- R9: For a load, lane o+k of each returned line is stored as transfer byte (bytes already answered + k). Here o is the piece's line offset: the start address offset for the first piece and 0 for the others. After completion, byte i of `rd_data` (bits 8i+7 .. 8i) holds memory byte start+i.
- R10: `done` is a one-cycle pulse that rises on the same clock edge that clears `busy`. A new request presented during the `done` cycle is accepted.
- R11: After reset, `busy`, `done` and `mreq_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A transfer request is presented |
| req_op | input | 2 | 2'b00 load, 2'b01 store, other codes illegal |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | $clog2(MAX_LEN+1) | Transfer length in bytes |
| req_wdata | input | MAX_LEN*8 | Store bytes, byte i at bits 8i+7..8i |
| req_ok | output | 1 | Request taken this cycle |
| req_full | output | 1 | Request refused because a transfer is active |
| req_err | output | 1 | Request refused as malformed |
| busy | output | 1 | A transfer is active |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | MAX_LEN*8 | Gathered load bytes, byte i at bits 8i+7..8i |
| mreq_valid | output | 1 | Memory piece presented |
| mreq_ready | input | 1 | Memory side takes the piece |
| mreq_write | output | 1 | Piece is a store |
| mreq_addr | output | ADDR_W | Byte address of the piece |
| mreq_line_addr | output | ADDR_W | Line-aligned address of the piece |
| mreq_len | output | $clog2(LINE_BYTES+1) | Piece length in bytes |
| mreq_data | output | LINE_BYTES*8 | Store bytes at their line lanes |
| mrsp_valid | input | 1 | Response (line data or acknowledgement) |
| mrsp_data | input | LINE_BYTES*8 | Returned line for loads |

## Verification
The bench builds the sequencer with a 16-byte line, a 64-byte maximum transfer and 16-bit addresses. With these values a single transfer can reach five lines: a clipped head, full middle lines and a short tail, all within a short run. The maximum length, exactly four aligned lines, also falls inside the tested set. The small line also lets a 1 KiB byte-addressed memory model serve every address the tests use. That model applies random ready stalls and random response delays, so holding a piece steady and the one-in-flight rule are both exercised under back-pressure.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

   localparam logic [1:0] OP_LOAD  = 2'b00;
   localparam logic [1:0] OP_STORE = 2'b01;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_ISSUE = 2'b01,
      ST_WAIT  = 2'b10
   } seq_state_e;

endpackage

// File: rtl/dmac_chunk_calc.sv
// Address and length of the piece that starts after done_len answered bytes.
module dmac_chunk_calc #(
   parameter  int ADDR_W     = 32,
   parameter  int LEN_W      = 9,
   parameter  int LINE_BYTES = 64,
   localparam int OFF_W      = $clog2(LINE_BYTES),
   localparam int CL_W       = $clog2(LINE_BYTES + 1)
) (
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [LEN_W-1:0]  total_len,
   input  logic [LEN_W-1:0]  done_len,
   output logic [ADDR_W-1:0] chunk_addr,
   output logic [OFF_W-1:0]  chunk_off,
   output logic [CL_W-1:0]   chunk_len
);
   localparam int CMP_W = (LEN_W > CL_W) ? LEN_W : CL_W;

   logic [CMP_W-1:0] room_w;
   logic [CMP_W-1:0] rest_w;

   assign chunk_addr = base_addr + ADDR_W'(done_len);
   assign chunk_off  = chunk_addr[OFF_W-1:0];
   assign room_w     = CMP_W'(LINE_BYTES) - CMP_W'(chunk_off);
   assign rest_w     = CMP_W'(total_len - done_len);
   assign chunk_len  = CL_W'((rest_w < room_w) ? rest_w : room_w);

endmodule

// File: rtl/dmac_byte_buf.sv
// Transfer byte store: loaded whole, filled from returned lines, sliced to lanes.
module dmac_byte_buf #(
   parameter  int MAX_LEN    = 256,
   parameter  int LINE_BYTES = 64,
   localparam int LEN_W      = $clog2(MAX_LEN + 1),
   localparam int IDX_W      = $clog2(MAX_LEN),
   localparam int OFF_W      = $clog2(LINE_BYTES),
   localparam int CL_W       = $clog2(LINE_BYTES + 1)
) (
   input  logic                    clk,
   input  logic                    load_en,
   input  logic [MAX_LEN*8-1:0]    load_bytes,
   input  logic                    fill_en,
   input  logic [LINE_BYTES*8-1:0] fill_line,
   input  logic [LEN_W-1:0]        fill_lo,
   input  logic [LEN_W-1:0]        fill_hi,
   input  logic [OFF_W-1:0]        fill_off,
   input  logic [LEN_W-1:0]        slice_lo,
   input  logic [OFF_W-1:0]        slice_off,
   input  logic [CL_W-1:0]         slice_len,
   output logic [LINE_BYTES*8-1:0] slice_line,
   output logic [MAX_LEN*8-1:0]    held_bytes
);
   localparam int SW = CL_W + 1;

   logic [7:0] held_q [MAX_LEN];
   logic [7:0] nxt    [MAX_LEN];

   for (genvar gi = 0; gi < MAX_LEN; gi++) begin : g_byte
      logic [LEN_W-1:0] rel;
      logic [OFF_W-1:0] lane;
      logic             in_win;
      assign rel    = LEN_W'(gi) - fill_lo;
      assign lane   = fill_off + OFF_W'(rel);
      assign in_win = (LEN_W'(gi) >= fill_lo) && (LEN_W'(gi) < fill_hi);
      assign nxt[gi] = load_en            ? load_bytes[gi*8 +: 8] :
                       (fill_en && in_win) ? fill_line[{lane, 3'b000} +: 8] :
                                             held_q[gi];
      assign held_bytes[gi*8 +: 8] = held_q[gi];
   end

   always_ff @(posedge clk) begin
      held_q <= nxt;
   end

   for (genvar gj = 0; gj < LINE_BYTES; gj++) begin : g_lane
      logic [LEN_W-1:0] pos;
      logic             hit;
      assign hit = (OFF_W'(gj) >= slice_off) &&
                   (SW'(gj) < SW'(slice_off) + SW'(slice_len));
      assign pos = slice_lo + LEN_W'(gj) - LEN_W'(slice_off);
      assign slice_line[gj*8 +: 8] = hit ? held_q[IDX_W'(pos)] : 8'h00;
   end

endmodule

// File: rtl/dma_chunker.sv
module dma_chunker
   import dmac_pkg::*;
#(
   parameter  int ADDR_W     = 32,
   parameter  int LINE_BYTES = 64,
   parameter  int MAX_LEN    = 256,
   localparam int LEN_W      = $clog2(MAX_LEN + 1),
   localparam int OFF_W      = $clog2(LINE_BYTES),
   localparam int CL_W       = $clog2(LINE_BYTES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [1:0]              req_op,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [LEN_W-1:0]        req_len,
   input  logic [MAX_LEN*8-1:0]    req_wdata,
   output logic                    req_ok,
   output logic                    req_full,
   output logic                    req_err,
   output logic                    busy,
   output logic                    done,
   output logic [MAX_LEN*8-1:0]    rd_data,
   output logic                    mreq_valid,
   input  logic                    mreq_ready,
   output logic                    mreq_write,
   output logic [ADDR_W-1:0]       mreq_addr,
   output logic [ADDR_W-1:0]       mreq_line_addr,
   output logic [CL_W-1:0]         mreq_len,
   output logic [LINE_BYTES*8-1:0] mreq_data,
   input  logic                    mrsp_valid,
   input  logic [LINE_BYTES*8-1:0] mrsp_data
);
   // elaboration-time parameter checks
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < 4) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 4");
   end
   if (MAX_LEN < 2) begin : g_bad_max
      $error("MAX_LEN must be at least 2");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W must exceed the line offset width");
   end

   seq_state_e        state_q;
   logic [ADDR_W-1:0] base_q;
   logic [LEN_W-1:0]  total_q;
   logic [LEN_W-1:0]  issued_q;
   logic [LEN_W-1:0]  answered_q;
   logic              write_q;
   logic              done_q;

   logic              op_legal;
   logic              len_legal;
   logic [ADDR_W-1:0] c_addr;
   logic [OFF_W-1:0]  c_off;
   logic [CL_W-1:0]   c_len;
   logic              fill_en;

   // request intake
   assign busy      = (state_q != ST_IDLE);
   assign op_legal  = (req_op == OP_LOAD) || (req_op == OP_STORE);
   assign len_legal = (req_len != '0) && (req_len <= LEN_W'(MAX_LEN));
   assign req_full  = req_valid && busy;
   assign req_ok    = req_valid && !busy && op_legal && len_legal;
   assign req_err   = req_valid && !busy && !(op_legal && len_legal);
   assign done      = done_q;

   dmac_chunk_calc #(
      .ADDR_W     (ADDR_W),
      .LEN_W      (LEN_W),
      .LINE_BYTES (LINE_BYTES)
   ) u_calc (
      .base_addr  (base_q),
      .total_len  (total_q),
      .done_len   (answered_q),
      .chunk_addr (c_addr),
      .chunk_off  (c_off),
      .chunk_len  (c_len)
   );

   assign fill_en = (state_q == ST_WAIT) && mrsp_valid && !write_q;

   dmac_byte_buf #(
      .MAX_LEN    (MAX_LEN),
      .LINE_BYTES (LINE_BYTES)
   ) u_buf (
      .clk        (clk),
      .load_en    (req_ok),
      .load_bytes ((req_op == OP_STORE) ? req_wdata : '0),
      .fill_en    (fill_en),
      .fill_line  (mrsp_data),
      .fill_lo    (answered_q),
      .fill_hi    (issued_q),
      .fill_off   (c_off),
      .slice_lo   (answered_q),
      .slice_off  (c_off),
      .slice_len  (c_len),
      .slice_line (mreq_data),
      .held_bytes (rd_data)
   );

   // downstream piece
   assign mreq_valid     = (state_q == ST_ISSUE);
   assign mreq_write     = write_q;
   assign mreq_addr      = c_addr;
   assign mreq_line_addr = {c_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign mreq_len       = c_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         base_q     <= '0;
         total_q    <= '0;
         issued_q   <= '0;
         answered_q <= '0;
         write_q    <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_ok) begin
                  base_q     <= req_addr;
                  total_q    <= req_len;
                  write_q    <= (req_op == OP_STORE);
                  issued_q   <= '0;
                  answered_q <= '0;
                  state_q    <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (mreq_ready) begin
                  issued_q <= issued_q + LEN_W'(c_len);
                  state_q  <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (mrsp_valid) begin
                  answered_q <= issued_q;
                  if (issued_q == total_q) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     state_q <= ST_ISSUE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // properties
   p_busy_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |-> (req_full && !req_ok));

   p_bad_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |=> !busy);

   p_chunk_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_valid |-> (mreq_len != '0 &&
         ((CL_W+1)'(mreq_addr[OFF_W-1:0]) + (CL_W+1)'(mreq_len) <= (CL_W+1)'(LINE_BYTES))));

   p_later_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq_valid && answered_q != '0) |-> (mreq_addr[OFF_W-1:0] == '0));

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr) && $stable(mreq_len)));

   p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mreq_valid && mreq_ready) |=> !mreq_valid);

   p_done_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

// File: tb/sim_dma_chunker.sv
module sim_dma_chunker;
   localparam int AW = 16;
   localparam int LB = 16;
   localparam int ML = 64;
   localparam int LW = $clog2(ML + 1);
   localparam int CW = $clog2(LB + 1);

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic            rst_n;
   logic            req_valid;
   logic [1:0]      req_op;
   logic [AW-1:0]   req_addr;
   logic [LW-1:0]   req_len;
   logic [ML*8-1:0] req_wdata;
   logic            req_ok, req_full, req_err, busy, done;
   logic [ML*8-1:0] rd_data;
   logic            mreq_valid, mreq_ready, mreq_write;
   logic [AW-1:0]   mreq_addr, mreq_line_addr;
   logic [CW-1:0]   mreq_len;
   logic [LB*8-1:0] mreq_data;
   logic            mrsp_valid;
   logic [LB*8-1:0] mrsp_data;

   dma_chunker #(.ADDR_W(AW), .LINE_BYTES(LB), .MAX_LEN(ML)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
      .req_len(req_len), .req_wdata(req_wdata),
      .req_ok(req_ok), .req_full(req_full), .req_err(req_err),
      .busy(busy), .done(done), .rd_data(rd_data),
      .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_write(mreq_write),
      .mreq_addr(mreq_addr), .mreq_line_addr(mreq_line_addr),
      .mreq_len(mreq_len), .mreq_data(mreq_data),
      .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data)
   );

   int n_chk = 0;
   int n_bad = 0;

   typedef struct {
      logic [AW-1:0]   addr;
      int              len;
      bit              wr;
      bit              first;
      logic [LB*8-1:0] data;
   } chunk_t;

   chunk_t     exp_q[$];
   logic [7:0] mem [0:1023];

   task automatic chk(input bit ok, input string tag,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [ML*8-1:0] pat(input int seed);
      logic [ML*8-1:0] v;
      for (int i = 0; i < ML; i++) v[i*8 +: 8] = 8'(seed + i * 13);
      return v;
   endfunction

   // driver side: expected pieces from the requirements
   task automatic plan_chunks(input bit wr, input logic [AW-1:0] a, input int len,
                              input logic [ML*8-1:0] wb);
      int sent = 0;
      while (sent < len) begin
         chunk_t c;
         int off, room, n;
         c.addr  = a + AW'(sent);
         off     = int'(c.addr) % LB;
         room    = LB - off;
         n       = (len - sent < room) ? len - sent : room;
         c.len   = n;
         c.wr    = wr;
         c.first = (sent == 0);
         c.data  = '0;
         if (wr) for (int j = 0; j < n; j++) c.data[(off+j)*8 +: 8] = wb[(sent+j)*8 +: 8];
         exp_q.push_back(c);
         sent += n;
      end
   endtask

   task automatic start_req(input logic [1:0] op, input logic [AW-1:0] a, input int len,
                            input logic [ML*8-1:0] wb, input string tag);
      plan_chunks(op == 2'b01, a, len, wb);
      req_valid = 1'b1; req_op = op; req_addr = a; req_len = LW'(len); req_wdata = wb;
      #1;
      chk(req_ok === 1'b1 && req_full === 1'b0 && req_err === 1'b0, tag,
          {req_ok, req_full, req_err}, 3'b100);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk(busy === 1'b1, "R1 busy after accept", busy, 1);
   endtask

   task automatic wait_done(input bit rd, input logic [AW-1:0] a, input int len);
      int t = 0;
      bit bad = 0;
      logic [7:0] ab = 0, eb = 0;
      while (done !== 1'b1 && t < 2000) begin
         @(negedge clk);
         #1;
         t++;
      end
      chk(done === 1'b1, "R10 done pulse seen", done, 1);
      chk(busy === 1'b0, "R10 busy clear with done", busy, 0);
      chk(exp_q.size() == 0, "R5 pieces cover length", exp_q.size(), 0);
      if (rd) begin
         for (int i = 0; i < len; i++) begin
            if (!bad && rd_data[i*8 +: 8] !== mem[(int'(a) + i) % 1024]) begin
               bad = 1; ab = rd_data[i*8 +: 8]; eb = mem[(int'(a) + i) % 1024];
            end
         end
         chk(!bad, "R9 gathered load bytes", ab, eb);
      end
   endtask

   // monitor and memory responder
   initial begin
      mreq_ready = 1'b0;
      mrsp_valid = 1'b0;
      mrsp_data  = '0;
      forever begin
         @(negedge clk);
         if (rst_n !== 1'b1) begin
            mreq_ready = 1'b0;
         end else begin
            mreq_ready = ($urandom % 3) != 0;
            if (mreq_valid === 1'b1 && mreq_ready) begin
               chunk_t        c;
               logic [AW-1:0] la;
               bit            w;
               int            off;
               la  = mreq_line_addr;
               w   = mreq_write;
               off = int'(mreq_addr) % LB;
               if (exp_q.size() == 0) begin
                  chk(0, "R2 unexpected piece", mreq_addr, 0);
               end else begin
                  c = exp_q.pop_front();
                  chk(mreq_addr === c.addr, c.first ? "R4 first address" : "R5 later address",
                      mreq_addr, c.addr);
                  chk(int'(mreq_len) == c.len, c.first ? "R4 first length" : "R5 later length",
                      mreq_len, c.len);
                  chk(mreq_line_addr === (c.addr & ~AW'(LB - 1)), "R7 line address",
                      mreq_line_addr, c.addr & ~AW'(LB - 1));
                  chk(mreq_write === c.wr, "R7 direction", mreq_write, c.wr);
                  if (c.wr) chk(mreq_data === c.data, "R8 store lanes", mreq_data, c.data);
               end
               if (w) begin
                  for (int j = 0; j < LB; j++)
                     if (j >= off && j < off + int'(mreq_len))
                        mem[(int'(la) + j) % 1024] = mreq_data[j*8 +: 8];
               end
               @(negedge clk);
               mreq_ready = 1'b0;
               chk(mreq_valid === 1'b0, "R6 one piece in flight", mreq_valid, 0);
               repeat ($urandom % 3) @(negedge clk);
               mrsp_valid = 1'b1;
               for (int j = 0; j < LB; j++)
                  mrsp_data[j*8 +: 8] = w ? 8'hEE : mem[(int'(la) + j) % 1024];
               @(negedge clk);
               mrsp_valid = 1'b0;
            end
         end
      end
   end

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [ML*8-1:0] wb;
      bit              same;
      for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 37 + 11);
      rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00; req_addr = '0; req_len = '0;
      req_wdata = '0;
      repeat (4) @(negedge clk);
      chk(busy === 1'b0 && mreq_valid === 1'b0 && done === 1'b0, "R11 reset idle",
          {busy, mreq_valid, done}, 3'b000);
      rst_n = 1'b1;
      @(negedge clk);

      // unaligned store across three lines: 13 + 16 + 11
      wb = pat(5);
      start_req(2'b01, 16'h0023, 40, wb, "R1 accept store");
      wait_done(0, 16'h0023, 40);

      // load the same span back
      start_req(2'b00, 16'h0023, 40, '0, "R1 accept load");
      wait_done(1, 16'h0023, 40);
      same = 1;
      for (int i = 0; i < 40; i++) if (rd_data[i*8 +: 8] !== wb[i*8 +: 8]) same = 0;
      chk(same, "R8 store then load round trip", same, 1);

      // sub-line load that fits inside one line
      start_req(2'b00, 16'h0105, 5, '0, "R1 accept sub-line");
      wait_done(1, 16'h0105, 5);
      @(negedge clk);
      #1;
      chk(done === 1'b0, "R10 done lasts one cycle", done, 0);

      // aligned maximum-length load: four full lines
      start_req(2'b00, 16'h0200, 64, '0, "R1 accept max length");
      wait_done(1, 16'h0200, 64);

      // store ending exactly on a line boundary, then read the line
      wb = pat(99);
      start_req(2'b01, 16'h030C, 4, wb, "R1 accept edge store");
      wait_done(0, 16'h030C, 4);
      start_req(2'b00, 16'h0300, 16, '0, "R1 accept line load");
      wait_done(1, 16'h0300, 16);

      // refusal while busy
      start_req(2'b00, 16'h0080, 33, '0, "R1 accept before refusal");
      req_valid = 1'b1; req_op = 2'b01; req_addr = 16'h0000; req_len = LW'(8);
      #1;
      chk(req_full === 1'b1 && req_ok === 1'b0 && req_err === 1'b0, "R2 refused while busy",
          {req_ok, req_full, req_err}, 3'b010);
      @(negedge clk);
      req_valid = 1'b0;
      wait_done(1, 16'h0080, 33);
      repeat (8) @(negedge clk);
      chk(busy === 1'b0 && mreq_valid === 1'b0, "R2 refused request not queued",
          {busy, mreq_valid}, 2'b00);

      // malformed requests
      begin
         logic [1:0] ops  [3] = '{2'b10, 2'b00, 2'b11};
         int         lens [3] = '{8, 0, 65};
         for (int k = 0; k < 3; k++) begin
            req_valid = 1'b1; req_op = ops[k]; req_addr = 16'h0040; req_len = LW'(lens[k]);
            #1;
            chk(req_err === 1'b1 && req_ok === 1'b0, "R3 malformed flagged",
                {req_ok, req_err}, 2'b01);
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            chk(busy === 1'b0 && mreq_valid === 1'b0, "R3 no transfer started",
                {busy, mreq_valid}, 2'b00);
         end
      end

      // back-to-back: second request presented in the done cycle
      wb = pat(41);
      start_req(2'b01, 16'h03B7, 20, wb, "R1 accept chained store");
      wait_done(0, 16'h03B7, 20);
      start_req(2'b00, 16'h03B0, 32, '0, "R10 accepted in done cycle");
      wait_done(1, 16'h03B0, 32);

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule